// File: doc/BRIEF.md
# Fail-Safe Bidirectional Pin Bank

This block controls a bank of general-purpose pins. Each pin has its own output-enable bit and its own output level. Both are held in two registers that software writes over a single-cycle register bus. A third bus location returns the synchronized pad levels of every pin, whatever its direction.

An abort input puts the whole bank into a safe state. While abort is high, no pin is driven, and external pull resistors set the pin levels. Software may still write the direction and data registers during abort. Those writes are stored, but they never turn on a driver, not even for a single cycle.

When abort drops, the stored directions come back on their own, two clock edges later, with no register rewrite. Turn-off acts at once from the raw abort input. Turn-on waits for the synchronized copy of abort to clear.

Top module: `gpio_abort_safe`

## Requirements
- R1: After reset, the direction register (address 0) and the data register (address 1) both read zero, and `pad_oe` and `pad_out` are all zero.
- R2: A write to address 0 stores the direction mask at the next clock edge. Outside abort, `pad_oe` then equals the mask (bit set = output), and `pad_oe` never has a bit set whose direction bit is clear.
- R3: A write to address 1 stores the output levels at the next clock edge. They appear on `pad_out` and read back at address 1.
- R4: While `abort_in` is high, `pad_oe` is all zero in the same cycle, with no clock edge needed.
- R5: Writes to address 0 or address 1 made during abort are stored and read back. `pad_oe` stays all zero for every cycle that abort is held.
- R6: After `abort_in` falls, `pad_oe` stays zero through the first clock edge. After the second clock edge it returns to the stored direction mask without any write. A one-cycle abort pulse also gives this clean off-then-on sequence.
- R7: Address 2 returns the pad levels of all pins through a two-flop synchronizer. A change on `pad_in` is visible after the second clock edge and not after the first.
- R8: Writes to address 2 or 3 change neither register, and address 3 reads zero.
- R9: Abort leaves the stored direction and data registers unchanged, so `pad_out` keeps its value through abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 direction, 1 data, 2 pad levels, 3 unused |
| bus_wdata | input | 14 | Write data |
| bus_rdata | output | 14 | Read data for `bus_addr`, combinational |
| abort_in | input | 1 | Abort request, forces every pin to input while high |
| pad_in | input | 14 | Pad levels from the pins |
| pad_out | output | 14 | Output levels to the pins |
| pad_oe | output | 14 | Per-pin output enable, 1 = drive |

## Verification
The bench checks `pad_oe` between clock edges right after abort rises. A design that clears the enable only through the synchronizer would drive the pins for up to two more cycles.

It writes an all-output mask while abort is held and checks every cycle for a stray enable. It also checks that the mask is kept, catching a design that either passes such writes through or drops them.

On release it counts edges exactly, so an early or late turn-on shows up. It also sends a one-cycle abort pulse, which exposes a design that turns the drivers back on for one cycle before its synchronized abort arrives. Finally, it checks the readback latency, and that writes to the unused addresses change neither register.

// File: rtl/gpio_abort_safe.sv
module gpio_abort_safe #(
  parameter int WIDTH  = 14,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              abort_in,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(2);

  logic [WIDTH-1:0] dir_q, dat_q, pin_m, pin_q;
  logic             abort_m, abort_q;
  logic             hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dat_q   <= '0;
      pin_m   <= '0;
      pin_q   <= '0;
      abort_m <= 1'b1;
      abort_q <= 1'b1;
    end else begin
      abort_m <= abort_in;
      abort_q <= abort_m;
      pin_m   <= pad_in;
      pin_q   <= pin_m;
      if (bus_wr && bus_addr == A_DIR)  dir_q <= bus_wdata;
      if (bus_wr && bus_addr == A_DATA) dat_q <= bus_wdata;
    end
  end

  assign hold    = abort_in | abort_m | abort_q;
  assign pad_oe  = hold ? '0 : dir_q;
  assign pad_out = dat_q;

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_DATA:  bus_rdata = dat_q;
      A_PINS:  bus_rdata = pin_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_abort_safe_chk.sv
module gpio_abort_safe_chk #(
  parameter int WIDTH  = 14,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              abort_in,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  dat_q
);
  assert_abort_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |-> pad_oe == '0);

  assert_oe_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  assert_dir_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> dir_q == $past(bus_wdata));

  assert_release_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_in) |=> pad_oe == '0);

  assert_release_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_in) ##1 !abort_in ##1 !abort_in |-> pad_oe == dir_q);

  assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= ADDR_W'(2)) |=> $stable(dir_q) && $stable(dat_q));

  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(dir_q) && $stable(dat_q));
endmodule

bind gpio_abort_safe gpio_abort_safe_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .abort_in(abort_in), .pad_oe(pad_oe),
  .dir_q(dir_q), .dat_q(dat_q)
);

// File: tb/sim_gpio_abort_safe.sv
`timescale 1ns/1ps
module sim_gpio_abort_safe;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         abort_in = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_abort_safe #(.WIDTH(W), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .abort_in(abort_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic edge_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #0.5;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    rd(2'd0, v); check("R1", "dir after reset", v, '0);
    rd(2'd1, v); check("R1", "data after reset", v, '0);
    check("R1", "oe after reset", pad_oe, '0);
    check("R1", "out after reset", pad_out, '0);
  endtask

  task automatic t_dir_data;
    logic [W-1:0] v;
    wr(2'd0, 14'h2A55);
    check("R2", "oe follows dir", pad_oe, 14'h2A55);
    wr(2'd1, 14'h1234);
    check("R3", "pad_out", pad_out, 14'h1234);
    rd(2'd1, v); check("R3", "data readback", v, 14'h1234);
    wr(2'd0, 14'h0F0F);
    check("R2", "oe second mask", pad_oe, 14'h0F0F);
  endtask

  task automatic t_abort_now;
    logic [W-1:0] v;
    @(negedge clk);
    abort_in = 1'b1;
    #0.5;
    check("R4", "oe immediately on abort", pad_oe, '0);
    edge_n(3);
    check("R4", "oe held in abort", pad_oe, '0);
    rd(2'd0, v); check("R9", "dir kept in abort", v, 14'h0F0F);
    check("R9", "pad_out kept in abort", pad_out, 14'h1234);
  endtask

  task automatic t_write_in_abort;
    logic [W-1:0] v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 14'h3FFF;
      #0.5;
      check("R5", "oe during write in abort", pad_oe, '0);
      @(posedge clk); #0.5;
      check("R5", "oe after write edge in abort", pad_oe, '0);
    end
    @(negedge clk); bus_wr = 1'b0; #0.5;
    rd(2'd0, v); check("R5", "dir stored in abort", v, 14'h3FFF);
    wr(2'd1, 14'h0AAA);
    check("R5", "oe after data write in abort", pad_oe, '0);
    rd(2'd1, v); check("R5", "data stored in abort", v, 14'h0AAA);
  endtask

  task automatic t_release;
    @(negedge clk);
    abort_in = 1'b0;
    #0.5;
    check("R6", "oe right after release", pad_oe, '0);
    edge_n(1);
    check("R6", "oe after first edge", pad_oe, '0);
    edge_n(1);
    check("R6", "oe after second edge", pad_oe, 14'h3FFF);
  endtask

  task automatic t_pulse;
    @(negedge clk); abort_in = 1'b1;
    #0.5; check("R6", "pulse oe in pulse", pad_oe, '0);
    @(negedge clk); abort_in = 1'b0;
    #0.5; check("R6", "pulse oe after drop", pad_oe, '0);
    edge_n(1); check("R6", "pulse oe one edge later", pad_oe, '0);
    edge_n(1); check("R6", "pulse oe restored", pad_oe, 14'h3FFF);
  endtask

  task automatic t_readback;
    logic [W-1:0] v;
    wr(2'd0, 14'h00FF);
    @(negedge clk);
    pad_in = 14'h15A3;
    edge_n(1);
    rd(2'd2, v); check("R7", "pins after one edge", v, '0);
    edge_n(1);
    rd(2'd2, v); check("R7", "pins after two edges", v, 14'h15A3);
  endtask

  task automatic t_unused;
    logic [W-1:0] v;
    wr(2'd2, 14'h1111);
    wr(2'd3, 14'h2222);
    rd(2'd0, v); check("R8", "dir after unused writes", v, 14'h00FF);
    rd(2'd1, v); check("R8", "data after unused writes", v, 14'h0AAA);
    rd(2'd3, v); check("R8", "addr 3 reads zero", v, '0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    edge_n(3);
    t_reset();
    rst_n = 1'b1;
    edge_n(3);
    t_reset();
    t_dir_data();
    t_abort_now();
    t_write_in_abort();
    t_release();
    t_pulse();
    t_readback();
    t_unused();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule